// File: doc/BRIEF.md
# Configurable Logic-Device Macrocell

This block is one output cell of a complex programmable logic device, written as ordinary synthesizable logic. Its configuration bits are static inputs. A sum-of-products term enters an XOR stage, which can invert it, combine it with a second term, or do both. The XOR result drives a combinational output directly. The same result, or a raw pad input, can instead be held in a storage element whose value appears on a second output. The two outputs are live at the same time, so the cell can carry a fast input register and an unrelated combinational function at once.

The storage element works either as an edge-triggered D register or as a transparent D latch. The clock comes from one of several global clocks or from a product-term clock. A selectable enable qualifies each update, so the clock itself is never gated. A global reset clears the stored value asynchronously, and its active level is set by a configuration bit.

Top module: `pld_macrocell`

## Requirements
- R1: `comb_out` equals `sop_in` XOR (`xor_term` AND `cfg_xor_en`) XOR `cfg_inv`.
- R2: `comb_out` has no storage in its path. It follows its inputs while any clock is high and with no clock edge.
- R3: With `cfg_latch`=0, on a rising edge of the selected clock with the enable active and reset inactive, `reg_out` takes the data input and holds it until the next such edge.
- R4: With `cfg_latch`=1, the selected clock is an active-high gate. While the gate is high and the enable is active, `reg_out` follows the data input. Otherwise it holds its value.
- R5: When the selected enable is inactive at a rising edge of the selected clock in register mode, `reg_out` keeps its previous value.
- R6: Reset is active when `rst_glb` equals `cfg_rst_high` (1 = active high, 0 = active low). It clears `reg_out` to 0 at once, without a clock, in both modes. It overrides the enable and the data input.
- R7: `cfg_clk_sel` values 0 to 2 pick `clk_glb[0]` to `clk_glb[2]`, and value 3 picks `clk_pt`. Edges and levels on the clocks that are not picked have no effect on `reg_out`.
- R8: `cfg_ce_pt`=0 takes the enable from `ce_glb`, and `cfg_ce_pt`=1 takes it from `ce_pt`.
- R9: `cfg_din_pad`=0 takes the stored data from the XOR stage output, and `cfg_din_pad`=1 takes it from `pad_in`.
- R10: Both storage forms track continuously. Changing `cfg_latch` at run time switches `reg_out` between the value last captured on an edge and the current latch value, without any clock or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_glb | input | NUM_GCLK | Global clocks |
| clk_pt | input | 1 | Product-term clock |
| ce_glb | input | 1 | Global clock enable, active high |
| ce_pt | input | 1 | Product-term clock enable, active high |
| rst_glb | input | 1 | Global reset, level set by `cfg_rst_high` |
| sop_in | input | 1 | Sum-of-products term |
| xor_term | input | 1 | Second XOR operand |
| pad_in | input | 1 | Direct input from the pad |
| cfg_latch | input | 1 | 1 = transparent latch, 0 = edge register |
| cfg_clk_sel | input | SEL_W | Clock source select |
| cfg_ce_pt | input | 1 | Enable source select |
| cfg_rst_high | input | 1 | Reset active level |
| cfg_din_pad | input | 1 | Storage data source select |
| cfg_xor_en | input | 1 | Enables `xor_term` in the XOR stage |
| cfg_inv | input | 1 | Inverts the XOR stage result |
| comb_out | output | 1 | Combinational output |
| reg_out | output | 1 | Stored output |

## Verification
The properties assume that configuration inputs and the selected source only change while every clock is low, so that switching the clock multiplexer never makes a spurious edge. They also assume that the data and enable are stable around each edge and each falling gate. A pending register-mode check may finish at the first edge after a configuration change, so the stimulus ends every configuration by capturing a 0 with the enable on. It then starts the next configuration with reset asserted. Data toggles only while a gate is high and well before it falls, and reset changes only between clock pulses or while a latch gate is held high.

// File: rtl/mc_pkg.sv
package mc_pkg;

    // static configuration of one macrocell, clock select kept apart
    // because its width follows the number of global clocks
    typedef struct packed {
        logic latch_mode;
        logic ce_from_pt;
        logic rst_active_high;
        logic d_from_pad;
        logic xor_enable;
        logic invert;
    } mc_cfg_t;

    typedef struct packed {
        logic flop;
    } mc_state_t;

endpackage

// File: rtl/mc_xor_stage.sv
module mc_xor_stage
    import mc_pkg::*;
(
    input  logic    sop,
    input  logic    xterm,
    input  mc_cfg_t cfg,
    output logic    comb
);

    always_comb begin
        comb = sop ^ (xterm & cfg.xor_enable) ^ cfg.invert;
    end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  mc_cfg_t cfg,
    input  logic    comb,
    input  logic    pad,
    input  logic    ce_g,
    input  logic    ce_p,
    input  logic    rst_in,
    output logic    d_sel,
    output logic    ce_act,
    output logic    rst_act
);

    always_comb begin
        d_sel   = cfg.d_from_pad ? pad : comb;
        ce_act  = cfg.ce_from_pt ? ce_p : ce_g;
        rst_act = cfg.rst_active_high ? rst_in : ~rst_in;
    end

endmodule

// File: rtl/mc_clk_mux.sv
module mc_clk_mux #(
    parameter int NUM_GCLK = 3,
    parameter int SEL_W    = 2
) (
    input  logic [NUM_GCLK-1:0] clk_g,
    input  logic                clk_p,
    input  logic [SEL_W-1:0]    sel,
    output logic                clk_out
);

    // codes below NUM_GCLK pick a global clock, any other the product-term one
    always_comb begin
        clk_out = clk_p;
        for (int i = 0; i < NUM_GCLK; i++) begin
            if (sel == SEL_W'(i)) clk_out = clk_g[i];
        end
    end

endmodule

// File: rtl/mc_store.sv
module mc_store
    import mc_pkg::*;
(
    input  logic clk_sel,
    input  logic rst_act,
    input  logic ce,
    input  logic d,
    input  logic latch_mode,
    output logic q
);

    mc_state_t st_d, st_q;
    logic      lat_q;

    // edge element: next value
    always_comb begin
        st_d      = st_q;
        if (ce) st_d.flop = d;
    end

    always_ff @(posedge clk_sel or posedge rst_act) begin
        if (rst_act) st_q <= '0;
        else         st_q <= st_d;
    end

    // level element: the selected clock is the active-high gate
    always_latch begin
        if (rst_act)          lat_q = 1'b0;
        else if (clk_sel && ce) lat_q = d;
    end

    assign q = latch_mode ? lat_q : st_q.flop;

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
    import mc_pkg::*;
#(
    parameter  int NUM_GCLK = 3,
    localparam int SEL_W    = $clog2(NUM_GCLK + 1)
) (
    input  logic [NUM_GCLK-1:0] clk_glb,
    input  logic                clk_pt,
    input  logic                ce_glb,
    input  logic                ce_pt,
    input  logic                rst_glb,
    input  logic                sop_in,
    input  logic                xor_term,
    input  logic                pad_in,
    input  logic                cfg_latch,
    input  logic [SEL_W-1:0]    cfg_clk_sel,
    input  logic                cfg_ce_pt,
    input  logic                cfg_rst_high,
    input  logic                cfg_din_pad,
    input  logic                cfg_xor_en,
    input  logic                cfg_inv,
    output logic                comb_out,
    output logic                reg_out
);

    mc_cfg_t cfg;
    logic    d_sel, ce_act, rst_act, clk_sel;

    always_comb begin
        cfg.latch_mode      = cfg_latch;
        cfg.ce_from_pt      = cfg_ce_pt;
        cfg.rst_active_high = cfg_rst_high;
        cfg.d_from_pad      = cfg_din_pad;
        cfg.xor_enable      = cfg_xor_en;
        cfg.invert          = cfg_inv;
    end

    mc_xor_stage u_xor (
        .sop   (sop_in),
        .xterm (xor_term),
        .cfg   (cfg),
        .comb  (comb_out)
    );

    mc_ctrl u_ctrl (
        .cfg     (cfg),
        .comb    (comb_out),
        .pad     (pad_in),
        .ce_g    (ce_glb),
        .ce_p    (ce_pt),
        .rst_in  (rst_glb),
        .d_sel   (d_sel),
        .ce_act  (ce_act),
        .rst_act (rst_act)
    );

    mc_clk_mux #(.NUM_GCLK(NUM_GCLK), .SEL_W(SEL_W)) u_cmux (
        .clk_g   (clk_glb),
        .clk_p   (clk_pt),
        .sel     (cfg_clk_sel),
        .clk_out (clk_sel)
    );

    mc_store u_store (
        .clk_sel    (clk_sel),
        .rst_act    (rst_act),
        .ce         (ce_act),
        .d          (d_sel),
        .latch_mode (cfg_latch),
        .q          (reg_out)
    );

endmodule

// File: rtl/mc_checker.sv
module mc_checker #(
    parameter  int NUM_GCLK = 3,
    localparam int SEL_W    = $clog2(NUM_GCLK + 1)
) (
    input logic [NUM_GCLK-1:0] clk_glb,
    input logic                clk_pt,
    input logic                ce_glb,
    input logic                ce_pt,
    input logic                rst_glb,
    input logic                pad_in,
    input logic                cfg_latch,
    input logic [SEL_W-1:0]    cfg_clk_sel,
    input logic                cfg_ce_pt,
    input logic                cfg_rst_high,
    input logic                cfg_din_pad,
    input logic                comb_out,
    input logic                reg_out
);

    logic pick_clk, en_now, d_now, rst_now;

    always_comb begin
        pick_clk = clk_pt;
        for (int i = 0; i < NUM_GCLK; i++) begin
            if (cfg_clk_sel == SEL_W'(i)) pick_clk = clk_glb[i];
        end
        en_now  = cfg_ce_pt ? ce_pt : ce_glb;
        d_now   = cfg_din_pad ? pad_in : comb_out;
        rst_now = (rst_glb == cfg_rst_high);
    end

    // R3: an enabled edge in register mode shows up by the next edge
    a_r3_edge_capture: assert property (@(posedge pick_clk) disable iff (rst_now)
        (!cfg_latch && en_now) |=> (cfg_latch || reg_out == $past(d_now)));

    // R5: a disabled edge leaves the stored value alone
    a_r5_ce_hold: assert property (@(posedge pick_clk) disable iff (rst_now)
        (!cfg_latch && !en_now) |=> (cfg_latch || $stable(reg_out)));

    // R4: the latch is transparent up to the falling gate
    a_r4_latch_follow: assert property (@(negedge pick_clk) disable iff (rst_now)
        (cfg_latch && en_now) |-> (reg_out == d_now));

    // R6: while reset is active the stored output is 0 (reset is the subject here)
    a_r6_reset_clear: assert property (@(negedge pick_clk)
        rst_now |-> (reg_out == 1'b0));

endmodule

bind pld_macrocell mc_checker #(.NUM_GCLK(NUM_GCLK)) u_mc_chk (
    .clk_glb      (clk_glb),
    .clk_pt       (clk_pt),
    .ce_glb       (ce_glb),
    .ce_pt        (ce_pt),
    .rst_glb      (rst_glb),
    .pad_in       (pad_in),
    .cfg_latch    (cfg_latch),
    .cfg_clk_sel  (cfg_clk_sel),
    .cfg_ce_pt    (cfg_ce_pt),
    .cfg_rst_high (cfg_rst_high),
    .cfg_din_pad  (cfg_din_pad),
    .comb_out     (comb_out),
    .reg_out      (reg_out)
);

// File: tb/pld_macrocell_test.sv
module pld_macrocell_test;

    logic       clk = 1'b0;
    logic [2:0] clk_glb = '0;
    logic       clk_pt = 1'b0;
    logic       ce_glb = 1'b0, ce_pt = 1'b0, rst_glb = 1'b1;
    logic       sop_in = 1'b0, xor_term = 1'b0, pad_in = 1'b0;
    logic       cfg_latch = 1'b0;
    logic [1:0] cfg_clk_sel = '0;
    logic       cfg_ce_pt = 1'b0, cfg_rst_high = 1'b1, cfg_din_pad = 1'b0;
    logic       cfg_xor_en = 1'b0, cfg_inv = 1'b0;
    logic       comb_out, reg_out;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [15:0] lf = 16'hACE1;
    logic mf = 1'b0, ml = 1'b0;

    pld_macrocell uut (.*);

    always #2 clk = ~clk; // 250 MHz

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 200000) begin
            n_chk++; n_bad++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic chk(input logic got, input logic exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic set_clk(input int k, input logic v);
        if (k < 3) clk_glb[k] = v;
        else       clk_pt     = v;
    endtask

    function automatic logic comb_m();
        return sop_in ^ (xor_term & cfg_xor_en) ^ cfg_inv;
    endfunction
    function automatic logic d_m();
        return cfg_din_pad ? pad_in : comb_m();
    endfunction
    function automatic logic ce_m();
        return cfg_ce_pt ? ce_pt : ce_glb;
    endfunction

    // {sop, xterm, xor_en, inv, pad, din_pad, exp_comb, exp_reg}
    localparam logic [7:0] VEC [13] = '{
        8'b000000_00, 8'b100000_11, 8'b110000_11, 8'b111000_00,
        8'b011000_11, 8'b000100_11, 8'b100100_00, 8'b011100_00,
        8'b111100_11, 8'b100001_10, 8'b000011_01, 8'b111111_11,
        8'b011001_10
    };

    initial begin
        // reset state, R6
        #3;
        chk(reg_out, 1'b0, "R6 reset state");
        chk(comb_out, 1'b0, "R1 reset state comb");
        rst_glb = 1'b0; ce_glb = 1'b1;
        #1;

        // vector table: register mode, clk_glb[0], global enable
        foreach (VEC[i]) begin
            {sop_in, xor_term, cfg_xor_en, cfg_inv, pad_in, cfg_din_pad} = VEC[i][7:2];
            #1;
            chk(comb_out, VEC[i][1], "R1 vector comb");
            clk_glb[0] = 1'b1; #1;
            clk_glb[0] = 1'b0; #1;
            chk(reg_out, VEC[i][0], "R3/R9 vector stored");
        end

        // sweep every configuration against the model
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cb;
            int sel;
            cb = 8'(c);
            clk_glb = '0; clk_pt = 1'b0;
            cfg_latch = cb[0]; cfg_clk_sel = cb[2:1]; cfg_ce_pt = cb[3];
            cfg_rst_high = cb[4]; cfg_din_pad = cb[5]; cfg_xor_en = cb[6];
            cfg_inv = cb[7];
            rst_glb = cfg_rst_high;
            sel = int'(cfg_clk_sel);
            mf = 1'b0; ml = 1'b0;
            #2;
            chk(reg_out, 1'b0, "R6 sweep reset");
            rst_glb = ~cfg_rst_high;
            #1;
            chk(reg_out, 1'b0, "R6 sweep after release");
            for (int s = 0; s < 6; s++) begin
                int k;
                string tag;
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                sop_in = lf[0]; xor_term = lf[1]; pad_in = lf[2];
                ce_glb = lf[3]; ce_pt = lf[4];
                k = int'(lf[6:5]);
                #1;
                chk(comb_out, comb_m(), "R1 sweep comb");
                if (k != sel)                 tag = "R7 unselected clock";
                else if (ce_glb != ce_pt)     tag = "R8 enable source";
                else if (!ce_m())             tag = "R5 disabled";
                else if (cfg_latch)           tag = "R4 latch";
                else                          tag = "R3 edge";
                set_clk(k, 1'b1);
                #1;
                if (k == sel && ce_m()) begin mf = d_m(); ml = d_m(); end
                chk(reg_out, cfg_latch ? ml : mf, tag);
                sop_in = ~sop_in; pad_in = ~pad_in;
                #1;
                chk(comb_out, comb_m(), "R2 comb with clock high");
                if (k == sel && ce_m()) ml = d_m();
                chk(reg_out, cfg_latch ? ml : mf, tag);
                set_clk(k, 1'b0);
                #1;
                chk(reg_out, cfg_latch ? ml : mf, tag);
            end
            // flush: capture 0 with enable on
            ce_glb = 1'b1; ce_pt = 1'b1; pad_in = 1'b0; xor_term = 1'b0;
            sop_in = cfg_inv;
            #1;
            set_clk(sel, 1'b1); #1;
            set_clk(sel, 1'b0); #1;
            chk(reg_out, 1'b0, "R3/R4 flush");
        end

        // R10: run-time mode switch
        cfg_latch = 1'b0; cfg_clk_sel = 2'd0; cfg_ce_pt = 1'b0;
        cfg_rst_high = 1'b1; cfg_din_pad = 1'b1; cfg_xor_en = 1'b0; cfg_inv = 1'b0;
        rst_glb = 1'b1; #1; rst_glb = 1'b0; #1;
        ce_glb = 1'b1; pad_in = 1'b1; #1;
        clk_glb[0] = 1'b1; #1;
        pad_in = 1'b0; #1;
        chk(reg_out, 1'b1, "R3 held through gate");
        clk_glb[0] = 1'b0; #1;
        cfg_latch = 1'b1; #1;
        chk(reg_out, 1'b0, "R10 switch to latch");
        cfg_latch = 1'b0; #1;
        chk(reg_out, 1'b1, "R10 switch to register");

        // R6: reset overrides an open latch
        cfg_latch = 1'b1; pad_in = 1'b1; #1;
        clk_glb[0] = 1'b1; #1;
        chk(reg_out, 1'b1, "R4 open latch");
        rst_glb = 1'b1; #1;
        chk(reg_out, 1'b0, "R6 async clear");
        pad_in = 1'b0; #1; pad_in = 1'b1; #1;
        chk(reg_out, 1'b0, "R6 overrides data");
        rst_glb = 1'b0; #1;
        chk(reg_out, 1'b1, "R4 follows after release");
        clk_glb[0] = 1'b0; #1;
        pad_in = 1'b0; #1;
        chk(reg_out, 1'b1, "R4 holds gate low");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule